// File: doc/BRIEF.md
# ADC Controller Register Sequencer

This block is the register-mapped front end of a single multi-channel successive-approximation converter. Software picks a channel and an input scale, turns the controller on, and requests a run of one or more samples. The block then issues one start pulse per sample to the converter. It counts the completions and keeps the last sample as the result. When the run is over it sets a raw completion flag, which software polls or takes as an interrupt.

A typical read goes like this. Software sets the enable bit and clears any stale completion. It writes the channel and scale, then the mode and sample count, and then sets the run bit. Once the raw flag is seen, software reads the result and drops the enable bit again. The converter itself sits outside the block, behind a start/done handshake.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `conv_start` is 0.
- R2: Reserved bits read as zero. Control (offset 0x00) reads back enable at bit 0, run at bit 1, wide mode at bit 2 and the sample count minus one at bits 7:4. Channel config (offset 0x04) reads back the channel at bits 4:0 and the scale at bits 10:9. Interrupt enable (offset 0x50) reads back bit 0 only.
- R3: The `conv_chan` and `conv_scale` outputs follow the channel config fields, and `conv_wide` follows control bit 2. The converter sees these values at every start pulse.
- R4: Writing control with bit 0 and bit 1 both set, while no run is active, starts a run. Run bit 1 reads 1 at once. Exactly N+1 one-cycle `conv_start` pulses follow, where N is bits 7:4. The run bit clears in the same cycle as the raw flag (offset 0x5C, bit 0) sets.
- R5: The result register (offset 0x4C) holds the sample from the final completion of the run in bits 11:0, and bits above 11 read zero.
- R6: Masked status (offset 0x58, bit 0) equals raw AND interrupt enable, and `irq` equals masked status.
- R7: Writing 1 to bit 0 of the clear register (offset 0x54) drops the raw flag. Writing 0 there leaves it unchanged.
- R8: A control write that has bit 1 set but bit 0 clear starts nothing. No start pulse is issued, the run bit stays 0 and the raw flag stays 0.
- R9: A control write with bit 0 clear during a run aborts it. The run bit drops, the raw flag is not set, and a completion that arrives afterwards changes neither the raw flag nor the result.
- R10: Reads of unmapped offsets, and of the write-only clear register, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| conv_start | output | 1 | One-cycle request for a single sample |
| conv_chan | output | CH_W | Selected channel |
| conv_scale | output | SC_W | Selected input scale |
| conv_wide | output | 1 | 12-bit mode select |
| conv_done | input | 1 | Converter sample complete |
| conv_data | input | RES_W | Converter sample value |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check the following on every cycle:
- start pulses never occur while the controller is disabled, and never on two cycles in a row;
- the raw flag rises only when the run bit falls;
- the run bit falls only after a completion or a disable;
- a clear write with no competing completion drops the raw flag;
- unmapped offsets read zero.

Only the bench scenarios can show the following:
- the number of start pulses per run and the result value chosen from the last sample;
- the channel and scale seen by the converter;
- that writing 0 to the clear register changes nothing;
- that a late completion after an abort leaves the result untouched.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CH_W   = 5,
  parameter int SC_W   = 2,
  parameter int RUN_W  = 4,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic [SC_W-1:0]   conv_scale,
  output logic              conv_wide,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_CFG  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'('h4C);
  localparam logic [ADDR_W-1:0] OFF_IE   = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'('h54);
  localparam logic [ADDR_W-1:0] OFF_STS  = ADDR_W'('h58);
  localparam logic [ADDR_W-1:0] OFF_RAW  = ADDR_W'('h5C);
  localparam int RUN_LSB = 4;
  localparam int SC_LSB  = 9;

  logic              en_q, run_q, wide_q, ie_q, raw_q, start_q;
  logic [RUN_W-1:0]  runs_q, cnt_q;
  logic [CH_W-1:0]   chan_q;
  logic [SC_W-1:0]   scale_q;
  logic [RES_W-1:0]  res_q;

  logic wr_ctrl, wr_cfg, wr_ie, wr_clr, kill, launch, last, finish;
  logic unused_wbits;

  assign wr_ctrl = wr_en && (addr == OFF_CTRL);
  assign wr_cfg  = wr_en && (addr == OFF_CFG);
  assign wr_ie   = wr_en && (addr == OFF_IE);
  assign wr_clr  = wr_en && (addr == OFF_CLR);
  assign kill    = wr_ctrl && !wdata[0];
  assign launch  = wr_ctrl && wdata[0] && wdata[1] && !run_q;
  assign last    = (cnt_q == runs_q);
  assign finish  = run_q && conv_done && last && !kill;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      wide_q  <= 1'b0;
      runs_q  <= '0;
      chan_q  <= '0;
      scale_q <= '0;
      ie_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata[0];
        wide_q <= wdata[2];
        runs_q <= wdata[RUN_LSB +: RUN_W];
      end
      if (wr_cfg) begin
        chan_q  <= wdata[CH_W-1:0];
        scale_q <= wdata[SC_LSB +: SC_W];
      end
      if (wr_ie) ie_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
      res_q   <= '0;
    end else if (kill) begin
      run_q   <= 1'b0;
      start_q <= 1'b0;
    end else if (launch) begin
      run_q   <= 1'b1;
      start_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      start_q <= 1'b0;
      if (run_q && conv_done) begin
        if (last) begin
          run_q <= 1'b0;
          res_q <= conv_data;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
          start_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     raw_q <= 1'b0;
    else if (finish)                raw_q <= 1'b1;
    else if (wr_clr && wdata[0])    raw_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CTRL: begin
        rdata[0] = en_q;
        rdata[1] = run_q;
        rdata[2] = wide_q;
        rdata[RUN_LSB +: RUN_W] = runs_q;
      end
      OFF_CFG: begin
        rdata[CH_W-1:0] = chan_q;
        rdata[SC_LSB +: SC_W] = scale_q;
      end
      OFF_DATA: rdata[RES_W-1:0] = res_q;
      OFF_IE:   rdata[0] = ie_q;
      OFF_STS:  rdata[0] = raw_q & ie_q;
      OFF_RAW:  rdata[0] = raw_q;
      default:  rdata = '0;
    endcase
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign conv_scale = scale_q;
  assign conv_wide  = wide_q;
  assign irq        = raw_q & ie_q;
endmodule

module adc_seq_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              conv_start,
  input logic              conv_done,
  input logic              en_q,
  input logic              run_q,
  input logic              raw_q
);
  logic mapped;
  assign mapped = (addr == ADDR_W'('h00)) || (addr == ADDR_W'('h04)) ||
                  (addr == ADDR_W'('h4C)) || (addr == ADDR_W'('h50)) ||
                  (addr == ADDR_W'('h58)) || (addr == ADDR_W'('h5C));

  // R8
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !conv_start);

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R4
  raw_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $fell(run_q));

  // R9
  run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (!en_q || $past(conv_done)));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h54) && wdata[0] && !conv_done) |=> !raw_q);

  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (rdata == '0));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .conv_start(conv_start), .conv_done(conv_done),
  .en_q(en_q), .run_q(run_q), .raw_q(raw_q)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        conv_start;
  logic [4:0]  conv_chan;
  logic [1:0]  conv_scale;
  logic        conv_wide;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  // converter model state (written only by the model)
  int          starts = 0;
  int          lat = 0;
  logic [4:0]  seen_chan = '0;
  logic [1:0]  seen_scale = '0;
  // bench-owned knobs
  int          mark = 0;
  logic [11:0] base = '0;

  always #10 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_scale(conv_scale), .conv_wide(conv_wide), .conv_done(conv_done),
    .conv_data(conv_data), .irq(irq)
  );

  initial begin
    forever begin
      @(posedge clk);
      conv_done <= 1'b0;
      if (lat > 0) begin
        lat = lat - 1;
        if (lat == 0) begin
          conv_done <= 1'b1;
          conv_data <= base + 12'(starts - mark - 1);
        end
      end else if (conv_start) begin
        lat = LAT;
        starts = starts + 1;
        seen_chan = conv_chan;
        seen_scale = conv_scale;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic summary;
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // {chan[4:0], scale[1:0], runs[3:0], ie, base[11:0]}
  localparam logic [23:0] VEC [0:5] = '{
    {5'd5,  2'd0, 4'd0,  1'b1, 12'hABC},
    {5'd1,  2'd3, 4'd1,  1'b0, 12'h100},
    {5'd31, 2'd2, 4'd3,  1'b1, 12'h7F0},
    {5'd14, 2'd1, 4'd15, 1'b1, 12'h001},
    {5'd0,  2'd3, 4'd7,  1'b0, 12'hFF0},
    {5'd20, 2'd1, 4'd2,  1'b1, 12'h555}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [11:0] last_res;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h04, v); chk("R1 cfg", v, 0);
    rd(8'h4C, v); chk("R1 data", v, 0);
    rd(8'h50, v); chk("R1 ie", v, 0);
    rd(8'h58, v); chk("R1 sts", v, 0);
    rd(8'h5C, v); chk("R1 raw", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 start", {31'd0, conv_start}, 0);

    // R2 field masking
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 cfg", v, 32'h0000_061F);
    wr(8'h00, 32'hFFFF_FFFD); rd(8'h00, v); chk("R2 ctrl", v, 32'h0000_00F5);
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, v); chk("R2 ie", v, 32'h1);
    wr(8'h00, 32'h0); wr(8'h50, 32'h0);

    // R10 unmapped and write-only
    rd(8'h08, v); chk("R10 0x08", v, 0);
    rd(8'h48, v); chk("R10 0x48", v, 0);
    rd(8'h60, v); chk("R10 0x60", v, 0);
    rd(8'hFC, v); chk("R10 0xFC", v, 0);
    rd(8'h54, v); chk("R10 clr", v, 0);

    // vector walk: R3 R4 R5 R6 R7
    for (int i = 0; i < 6; i++) begin
      logic [4:0]  ch;
      logic [1:0]  sc;
      logic [3:0]  rn;
      logic        ie;
      logic [31:0] ctl;
      bit          seen;
      {ch, sc, rn, ie, base} = VEC[i];
      ctl = 32'h5 | (32'(rn) << 4);
      wr(8'h00, 32'h1);
      wr(8'h54, 32'h1);
      wr(8'h50, {31'd0, ie});
      wr(8'h04, (32'(sc) << 9) | 32'(ch));
      wr(8'h00, ctl);
      chk("R3 chan out", {27'd0, conv_chan}, {27'd0, ch});
      chk("R3 scale out", {30'd0, conv_scale}, {30'd0, sc});
      chk("R3 wide out", {31'd0, conv_wide}, 1);
      mark = starts;
      wr(8'h00, ctl | 32'h2);
      rd(8'h00, v); chk("R4 run set", {31'd0, v[1]}, 1);
      seen = 0;
      for (int k = 0; k < 400 && !seen; k++) begin
        rd(8'h5C, v);
        if (v[0]) seen = 1;
      end
      chk("R4 raw set", {31'd0, seen}, 1);
      rd(8'h00, v); chk("R4 run cleared", v, ctl);
      chk("R4 sample count", 32'(starts - mark), 32'(rn) + 1);
      chk("R3 chan seen", {27'd0, seen_chan}, {27'd0, ch});
      chk("R3 scale seen", {30'd0, seen_scale}, {30'd0, sc});
      rd(8'h4C, v); chk("R5 result", v, 32'(base + 12'(rn)));
      rd(8'h58, v); chk("R6 status", v, {31'd0, ie});
      chk("R6 irq", {31'd0, irq}, {31'd0, ie});
      wr(8'h54, 32'h0);
      rd(8'h5C, v); chk("R7 clear 0", v, 1);
      wr(8'h54, 32'h1);
      rd(8'h5C, v); chk("R7 clear 1", v, 0);
      chk("R7 irq low", {31'd0, irq}, 0);
      wr(8'h00, 32'h0);
    end
    last_res = base + 12'd2;

    // R8 start while disabled
    mark = starts;
    wr(8'h00, 32'h2);
    rd(8'h00, v); chk("R8 run stays 0", v, 0);
    repeat (10) @(negedge clk);
    chk("R8 no start", 32'(starts - mark), 0);
    rd(8'h5C, v); chk("R8 raw 0", v, 0);

    // R9 abort mid-run
    wr(8'h50, 32'h1);
    base = 12'h3C3;
    wr(8'h00, 32'h1);
    mark = starts;
    wr(8'h00, 32'h3);
    wr(8'h00, 32'h0);
    rd(8'h00, v); chk("R9 run dropped", v, 0);
    repeat (12) @(negedge clk);
    chk("R9 one start", 32'(starts - mark), 1);
    rd(8'h5C, v); chk("R9 raw 0", v, 0);
    rd(8'h4C, v); chk("R9 result kept", v, {20'd0, last_res});
    chk("R9 irq 0", {31'd0, irq}, 0);

    summary();
  end
endmodule